// File: doc/BRIEF.md
# Program Counter and Memory Address Generator

This block produces the address for a small word-addressed memory. It holds two address sources. One is a program counter that steps through memory one word at a time, so instructions are fetched in order. The other is a memory address register that takes its value from a data bus, so data can be read or written at any location.

A select input chooses which register drives the address output. The surrounding controller asserts the advance strobe once per instruction, and loads the address register whenever an operand address appears on the bus. The counter's carry-out is exported so the controller can see when the counter passes its top value and returns to zero. The address width is a parameter and defaults to 4 bits, which covers 16 words. A second parameter chooses between a half-adder ripple chain and a plain adder for the incrementer.

Top module: `addr_gen_unit`

## Requirements
- R1: While `reset` is high at a rising edge of `clk`, both the program counter and the memory address register become 0, so `addr` reads 0 for either value of `use_pc` after that edge.
- R2: At a rising edge with `reset` low and `inc_pc` high, the program counter becomes its previous value plus one.
- R3: At a rising edge with `reset` low and `inc_pc` low, the program counter keeps its value.
- R4: With the default 4-bit width, the program counter moves from 15 to 0 when it advances.
- R5: `pc_carry` is 1 exactly when `inc_pc` is high and the program counter holds its all-ones value (15 by default), and is 0 otherwise. It is combinational, within the same cycle.
- R6: At a rising edge with `reset` low and `load_mar` high, the memory address register takes the value on `data_bus`.
- R7: At a rising edge with `load_mar` low, the memory address register keeps its value, whatever is on `data_bus`.
- R8: `addr` equals the program counter while `use_pc` is 1 and equals the memory address register while `use_pc` is 0. It follows `use_pc` within the same cycle.
- R9: When `inc_pc` and `load_mar` are both high at one edge, the counter advances and the address register loads, each as if alone.
- R10: `reset` overrides `inc_pc` and `load_mar` at the same edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| reset | input | 1 | Synchronous reset, active high |
| inc_pc | input | 1 | Advance the program counter at the next edge |
| load_mar | input | 1 | Load the address register from the data bus at the next edge |
| use_pc | input | 1 | 1 selects the program counter onto `addr`, 0 selects the address register |
| data_bus | input | ADDR_W (4) | Value loaded into the address register |
| addr | output | ADDR_W (4) | Memory address |
| pc_carry | output | 1 | Incrementer carry-out; high when the counter is about to pass its top value |

## Verification
The bench builds the block with its default values: a 4-bit address and the ripple-chain incrementer. The counter space is then only 16 words, so a directed walk reaches the 15-to-0 wrap and the carry pulse within a few dozen cycles. It also tests every stage of the half-adder chain under a carry. At the same width, each address-register load pattern and each clash between the control strobes can be checked against a simple model in the bench.

// File: rtl/addr_gen_pkg.sv
package addr_gen_pkg;

   // Implementation variant of the program-counter incrementer
   typedef enum logic [0:0] {
      INC_RIPPLE = 1'b0,   // explicit half-adder chain
      INC_ADDER  = 1'b1    // single behavioural add
   } inc_style_e;

   localparam int unsigned ADDR_W_MAX = 32;

endpackage

// File: rtl/ag_incrementer.sv
module ag_incrementer
   import addr_gen_pkg::*;
#(
   parameter int unsigned W     = 4,
   parameter inc_style_e  STYLE = INC_RIPPLE
) (
   input  logic [W-1:0] val_i,
   input  logic         cin_i,
   output logic [W-1:0] sum_o,
   output logic         cout_o
);

   if (STYLE == INC_RIPPLE) begin : g_ripple
      logic [W:0] carry;
      assign carry[0] = cin_i;
      for (genvar i = 0; i < W; i++) begin : g_stage
         // half adder: sum is xor, carry is and
         assign sum_o[i]    = val_i[i] ^ carry[i];
         assign carry[i+1]  = val_i[i] & carry[i];
      end
      assign cout_o = carry[W];
   end else begin : g_adder
      logic [W:0] wide;
      assign wide   = {1'b0, val_i} + {{W{1'b0}}, cin_i};
      assign sum_o  = wide[W-1:0];
      assign cout_o = wide[W];
   end

endmodule

// File: rtl/ag_reg.sv
module ag_reg #(
   parameter int unsigned W = 4
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         en,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   always_ff @(posedge clk) begin
      if (rst)
         q <= '0;
      else if (en)
         q <= d;
   end

endmodule

// File: rtl/ag_addr_mux.sv
module ag_addr_mux #(
   parameter int unsigned W = 4
) (
   input  logic         sel_a,
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   output logic [W-1:0] y
);

   for (genvar i = 0; i < W; i++) begin : g_bit
      assign y[i] = sel_a ? a[i] : b[i];
   end

endmodule

// File: rtl/addr_gen_unit.sv
module addr_gen_unit
   import addr_gen_pkg::*;
#(
   parameter int unsigned ADDR_W    = 4,
   parameter inc_style_e  INC_STYLE = INC_RIPPLE
) (
   input  logic              clk,
   input  logic              reset,
   input  logic              inc_pc,
   input  logic              load_mar,
   input  logic              use_pc,
   input  logic [ADDR_W-1:0] data_bus,
   output logic [ADDR_W-1:0] addr,
   output logic              pc_carry
);

   localparam int unsigned WORDS = 1 << ADDR_W;

   if (ADDR_W < 1 || ADDR_W > ADDR_W_MAX) begin : g_bad_width
      $error("addr_gen_unit: ADDR_W out of range");
   end
   if (WORDS < 2) begin : g_bad_words
      $error("addr_gen_unit: address space too small");
   end

   logic [ADDR_W-1:0] pc_q;
   logic [ADDR_W-1:0] pc_next;
   logic [ADDR_W-1:0] mar_q;

   // The increment strobe is the carry-in, so the counter reloads every cycle
   ag_incrementer #(.W(ADDR_W), .STYLE(INC_STYLE)) u_inc (
      .val_i  (pc_q),
      .cin_i  (inc_pc),
      .sum_o  (pc_next),
      .cout_o (pc_carry)
   );

   ag_reg #(.W(ADDR_W)) u_pc (
      .clk (clk),
      .rst (reset),
      .en  (1'b1),
      .d   (pc_next),
      .q   (pc_q)
   );

   ag_reg #(.W(ADDR_W)) u_mar (
      .clk (clk),
      .rst (reset),
      .en  (load_mar),
      .d   (data_bus),
      .q   (mar_q)
   );

   ag_addr_mux #(.W(ADDR_W)) u_mux (
      .sel_a (use_pc),
      .a     (pc_q),
      .b     (mar_q),
      .y     (addr)
   );

endmodule

// File: rtl/addr_gen_chk.sv
module addr_gen_chk #(
   parameter int unsigned ADDR_W = 4
) (
   input logic              clk,
   input logic              reset,
   input logic              inc_pc,
   input logic              load_mar,
   input logic              use_pc,
   input logic [ADDR_W-1:0] data_bus,
   input logic [ADDR_W-1:0] addr,
   input logic              pc_carry,
   input logic [ADDR_W-1:0] pc_q,
   input logic [ADDR_W-1:0] mar_q
);

   // R1 R10
   reset_clear_chk: assert property (@(posedge clk)
      reset |=> (pc_q == '0 && mar_q == '0));

   // R2 R9
   pc_step_chk: assert property (@(posedge clk) disable iff (reset)
      inc_pc |=> pc_q == ADDR_W'($past(pc_q) + 1'b1));

   // R3
   pc_hold_chk: assert property (@(posedge clk) disable iff (reset)
      !inc_pc |=> $stable(pc_q));

   // R4 R5
   carry_wrap_chk: assert property (@(posedge clk) disable iff (reset)
      pc_carry |=> pc_q == '0);

   // R5
   carry_only_top_chk: assert property (@(posedge clk) disable iff (reset)
      pc_carry |-> (inc_pc && (&pc_q)));

   // R6 R9
   mar_load_chk: assert property (@(posedge clk) disable iff (reset)
      load_mar |=> mar_q == $past(data_bus));

   // R7
   mar_hold_chk: assert property (@(posedge clk) disable iff (reset)
      !load_mar |=> $stable(mar_q));

   // R8
   sel_pc_chk: assert property (@(posedge clk) disable iff (reset)
      use_pc |-> addr == pc_q);

   // R8
   sel_mar_chk: assert property (@(posedge clk) disable iff (reset)
      !use_pc |-> addr == mar_q);

endmodule

bind addr_gen_unit addr_gen_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk      (clk),
   .reset    (reset),
   .inc_pc   (inc_pc),
   .load_mar (load_mar),
   .use_pc   (use_pc),
   .data_bus (data_bus),
   .addr     (addr),
   .pc_carry (pc_carry),
   .pc_q     (pc_q),
   .mar_q    (mar_q)
);

// File: tb/sim_addr_gen_unit.sv
module sim_addr_gen_unit;

   localparam int CLK_PERIOD = 10;
   localparam int W = 4;

   logic         clk = 1'b0;
   logic         reset;
   logic         inc_pc;
   logic         load_mar;
   logic         use_pc;
   logic [W-1:0] data_bus;
   logic [W-1:0] addr;
   logic         pc_carry;

   int total = 0;
   int bad   = 0;

   logic [W-1:0] m_pc;
   logic [W-1:0] m_mar;

   always #(CLK_PERIOD/2) clk = ~clk;

   addr_gen_unit #(.ADDR_W(W)) u0 (
      .clk      (clk),
      .reset    (reset),
      .inc_pc   (inc_pc),
      .load_mar (load_mar),
      .use_pc   (use_pc),
      .data_bus (data_bus),
      .addr     (addr),
      .pc_carry (pc_carry)
   );

   task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: got %0d expected %0d", req, act, exp);
      end
   endtask

   // one rising edge; returns just after the following falling edge
   task automatic tick();
      @(posedge clk);
      @(negedge clk);
      #1;
   endtask

   task automatic look_pc(input string req);
      use_pc = 1'b1; #1;
      check(req, addr, m_pc);
   endtask

   task automatic look_mar(input string req);
      use_pc = 1'b0; #1;
      check(req, addr, m_mar);
   endtask

   task automatic do_reset();
      reset = 1'b1; inc_pc = 1'b0; load_mar = 1'b0; data_bus = '0;
      tick(); tick();
      reset = 1'b0;
      m_pc = '0; m_mar = '0;
   endtask

   task automatic t_reset_state();
      look_pc("R1 pc after reset");
      look_mar("R1 mar after reset");
   endtask

   task automatic t_count_and_hold();
      for (int k = 0; k < 5; k++) begin
         inc_pc = 1'b1; tick(); m_pc = m_pc + 1'b1;
         look_pc("R2 pc advance");
      end
      inc_pc = 1'b0;
      for (int k = 0; k < 3; k++) begin
         tick();
         look_pc("R3 pc hold");
      end
   endtask

   task automatic t_wrap_carry();
      inc_pc = 1'b0; #1;
      check("R5 carry low when idle", {3'b0, pc_carry}, 4'd0);
      while (m_pc != 4'd15) begin
         inc_pc = 1'b1; #1;
         check("R5 carry low below top", {3'b0, pc_carry}, 4'd0);
         tick(); m_pc = m_pc + 1'b1;
      end
      look_pc("R2 pc reached top");
      inc_pc = 1'b0; #1;
      check("R5 carry low at top without inc", {3'b0, pc_carry}, 4'd0);
      inc_pc = 1'b1; #1;
      check("R5 carry high at top with inc", {3'b0, pc_carry}, 4'd1);
      tick(); m_pc = 4'd0;
      look_pc("R4 wrap to zero");
      inc_pc = 1'b0; #1;
      check("R5 carry low after wrap", {3'b0, pc_carry}, 4'd0);
   endtask

   task automatic t_mar_load();
      logic [W-1:0] pats [4] = '{4'd9, 4'd0, 4'd15, 4'd6};
      foreach (pats[k]) begin
         load_mar = 1'b1; data_bus = pats[k];
         tick(); m_mar = pats[k];
         load_mar = 1'b0;
         look_mar("R6 mar load");
      end
      data_bus = 4'd3;
      tick();
      look_mar("R7 mar ignores bus");
      data_bus = 4'd12;
      tick();
      look_mar("R7 mar ignores bus again");
   endtask

   task automatic t_select();
      inc_pc = 1'b1; tick(); m_pc = m_pc + 1'b1; inc_pc = 1'b0;
      for (int k = 0; k < 3; k++) begin
         look_pc("R8 select pc");
         look_mar("R8 select mar");
      end
   endtask

   task automatic t_both();
      inc_pc = 1'b1; load_mar = 1'b1; data_bus = 4'd10;
      tick(); m_pc = m_pc + 1'b1; m_mar = 4'd10;
      inc_pc = 1'b0; load_mar = 1'b0;
      look_pc("R9 pc with load");
      look_mar("R9 mar with inc");
   endtask

   task automatic t_reset_priority();
      inc_pc = 1'b1; load_mar = 1'b1; data_bus = 4'd5; reset = 1'b1;
      tick();
      reset = 1'b0; inc_pc = 1'b0; load_mar = 1'b0;
      m_pc = '0; m_mar = '0;
      look_pc("R10 reset beats inc");
      look_mar("R10 reset beats load");
   endtask

   initial begin
      reset = 1'b1; inc_pc = 1'b0; load_mar = 1'b0; use_pc = 1'b1; data_bus = '0;
      m_pc = '0; m_mar = '0;
      @(negedge clk);
      do_reset();
      t_reset_state();
      t_count_and_hold();
      t_wrap_carry();
      t_mar_load();
      t_select();
      t_both();
      t_reset_priority();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 5000);
      total++;
      bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule